// File: doc/BRIEF.md
# Register Rename Map with Move Elimination

This block holds the mapping from architectural register numbers to physical register tags for an out-of-order core. Each cycle it accepts a group of up to `LANES` decoded instructions. It returns the physical tags of their source operands. For every instruction that writes a register, it records the destination tag that an external allocator has supplied for that lane.

A register-to-register MOVE is resolved inside the map and never executes. The destination entry takes the source's current tag, no new tag is consumed, and the lane is flagged as a no-op so that dispatch can drop it. Two architectural numbers are reserved. One stands for the instruction pointer and the other for a hardwired zero. Neither is held in the renamed state, and each reads back as a fixed tag.

The block keeps a small bank of snapshot slots. A snapshot can be saved per branch and reloaded in a single cycle when that branch turns out mispredicted.

Top module: `regmap_movelim`

## Requirements
- R1: A valid non-move lane with `grp_wr`=1 and a destination other than 62 or 63 sets `lane_alloc`=1, drives its `grp_newtag` value on `dst_tag`, and later reads of that register return that tag.
- R2: A valid lane's `tag_a`/`tag_b` return the current mapping of `grp_srca`/`grp_srcb` for registers 0..61.
- R3: A valid MOVE lane whose source (`grp_srca`) is not 62 sets `lane_nop`=1 and `lane_alloc`=0. It maps the destination to the source's current tag, which it also drives on `dst_tag`.
- R4: Register 62 (instruction pointer) reads as tag `IP_TAG` (default 62). Writes to it are not recorded and allocate nothing. A MOVE whose source is 62 is not eliminated and is handled as an ordinary writing instruction.
- R5: Register 63 reads as tag `ZERO_TAG` (default 63). Writes to it are discarded and allocate nothing. A MOVE into 63 is still flagged as a no-op.
- R6: Register 0 is renamed like any other general register.
- R7: Within one group, lane j reads mappings written by lanes below j, including mappings copied by a MOVE. If two lanes write the same register, the higher lane's mapping survives.
- R8: With `snap_save`=1, slot `save_slot` captures the map as it stands after the current cycle's update.
- R9: With `snap_restore`=1, the map of the next cycle equals the contents of slot `restore_slot`. The group presented in that cycle has no effect, and `lane_nop` and `lane_alloc` are 0 for every lane.
- R10: After reset, register r (r < 62) maps to tag r, and every snapshot slot holds that same map.
- R11: A lane with `grp_valid`=0 changes nothing and drives `lane_nop`=0 and `lane_alloc`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | LANES | Lane carries an instruction |
| grp_move | input | LANES | Lane is a register-to-register MOVE (source on A) |
| grp_wr | input | LANES | Lane writes a destination register |
| grp_dst | input | LANES*AW | Destination register number per lane |
| grp_srca | input | LANES*AW | Source A register number per lane |
| grp_srcb | input | LANES*AW | Source B register number per lane |
| grp_newtag | input | LANES*TAG_W | Freshly allocated tag offered per lane |
| snap_save | input | 1 | Save the post-update map into a slot |
| save_slot | input | SW | Slot written on save |
| snap_restore | input | 1 | Reload the map from a slot |
| restore_slot | input | SW | Slot read on restore |
| tag_a | output | LANES*TAG_W | Physical tag of source A |
| tag_b | output | LANES*TAG_W | Physical tag of source B |
| dst_tag | output | LANES*TAG_W | Tag recorded for the destination |
| lane_nop | output | LANES | Lane was resolved as an eliminated MOVE |
| lane_alloc | output | LANES | Lane consumed its offered new tag |

## Verification
The bench targets MOVE chains inside a single group. A design that read only the registered map would hand a later lane a stale tag. It also covers a MOVE whose source is the instruction pointer: a design that eliminated it would alias a general register to a value that never stays still. Writes and moves into register 63 are exercised, since a leaking write would corrupt the zero tag. Restore cycles that also present a full group are exercised too, where a design that let the group through would leave mappings behind the reloaded snapshot or raise `lane_alloc` and leak tags.

// File: rtl/regmap_pkg.sv
package regmap_pkg;

   // Classification of one lane in a rename group.
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,   // no instruction
      LK_PLAIN = 2'd1,   // writes a general register with a fresh tag
      LK_ELIM  = 2'd2,   // move resolved inside the map
      LK_NODST = 2'd3    // nothing recorded (no dst, or reserved dst)
   } lane_kind_e;

   localparam int unsigned DEF_NAREG    = 64;
   localparam int unsigned DEF_IP_REG   = 62;
   localparam int unsigned DEF_ZERO_REG = 63;

endpackage

// File: rtl/regmap_lane.sv
module regmap_lane
   import regmap_pkg::*;
#(
   parameter int unsigned NAREG    = 64,
   parameter int unsigned AW       = 6,
   parameter int unsigned TW       = 8,
   parameter int unsigned IP_REG   = 62,
   parameter int unsigned ZERO_REG = 63,
   parameter int unsigned IP_TAG   = 62,
   parameter int unsigned ZERO_TAG = 63
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NAREG-1:0][TW-1:0]  map_i,
   output logic [NAREG-1:0][TW-1:0]  map_o,
   input  logic                      valid,
   input  logic                      is_move,
   input  logic                      has_dst,
   input  logic [AW-1:0]             dst,
   input  logic [AW-1:0]             srca,
   input  logic [AW-1:0]             srcb,
   input  logic [TW-1:0]             new_tag,
   output logic [TW-1:0]             tag_a,
   output logic [TW-1:0]             tag_b,
   output logic [TW-1:0]             dst_tag,
   output logic                      nop,
   output logic                      alloc
);

   localparam logic [AW-1:0] IPR = AW'(IP_REG);
   localparam logic [AW-1:0] ZR  = AW'(ZERO_REG);
   localparam logic [TW-1:0] IPT = TW'(IP_TAG);
   localparam logic [TW-1:0] ZT  = TW'(ZERO_TAG);

   lane_kind_e kind;
   logic       rsvd_dst;
   logic       wr_en;

   always_comb begin
      if (srca == IPR)      tag_a = IPT;
      else if (srca == ZR)  tag_a = ZT;
      else                  tag_a = map_i[srca];

      if (srcb == IPR)      tag_b = IPT;
      else if (srcb == ZR)  tag_b = ZT;
      else                  tag_b = map_i[srcb];

      rsvd_dst = (dst == IPR) || (dst == ZR);

      if (!valid)                                  kind = LK_IDLE;
      else if (is_move && (srca != IPR))           kind = LK_ELIM;
      else if (has_dst && !rsvd_dst)               kind = LK_PLAIN;
      else                                         kind = LK_NODST;

      nop     = (kind == LK_ELIM);
      alloc   = (kind == LK_PLAIN);
      wr_en   = alloc || (nop && !rsvd_dst);
      dst_tag = nop ? tag_a : new_tag;

      map_o = map_i;
      if (wr_en) map_o[dst] = dst_tag;
   end

   // R3
   move_elim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && is_move && srca != IPR) |-> (nop && !alloc && dst_tag == tag_a));

   // R5
   zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && srcb == ZR) |-> (tag_b == ZT));

   // R11
   idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |-> (!nop && !alloc && map_o == map_i));

   // R4
   ip_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && is_move && has_dst && srca == IPR && !rsvd_dst) |-> (alloc && !nop));

endmodule

// File: rtl/regmap_ckpt.sv
module regmap_ckpt #(
   parameter int unsigned NSLOT = 4,
   parameter int unsigned NAREG = 64,
   parameter int unsigned TW    = 8,
   parameter int unsigned SW    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [SW-1:0]             wr_slot,
   input  logic [NAREG-1:0][TW-1:0]  wr_map,
   input  logic [SW-1:0]             rd_slot,
   output logic [NAREG-1:0][TW-1:0]  rd_map
);

   logic [NSLOT-1:0][NAREG-1:0][TW-1:0] slot_q;

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int r = 0; r < NAREG; r++) slot_q[s][r] <= TW'(r);
         end else if (wr_en && (wr_slot == SW'(s))) begin
            slot_q[s] <= wr_map;
         end
      end
   end

   assign rd_map = slot_q[rd_slot];

endmodule

// File: rtl/regmap_movelim.sv
module regmap_movelim
   import regmap_pkg::*;
#(
   parameter int unsigned LANES    = 4,
   parameter int unsigned NAREG    = DEF_NAREG,
   parameter int unsigned TAG_W    = 8,
   parameter int unsigned NCKPT    = 4,
   parameter int unsigned IP_REG   = DEF_IP_REG,
   parameter int unsigned ZERO_REG = DEF_ZERO_REG,
   parameter int unsigned IP_TAG   = 62,
   parameter int unsigned ZERO_TAG = 63,
   localparam int unsigned AW      = $clog2(NAREG),
   localparam int unsigned SW      = $clog2(NCKPT)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        grp_valid,
   input  logic [LANES-1:0]        grp_move,
   input  logic [LANES-1:0]        grp_wr,
   input  logic [LANES*AW-1:0]     grp_dst,
   input  logic [LANES*AW-1:0]     grp_srca,
   input  logic [LANES*AW-1:0]     grp_srcb,
   input  logic [LANES*TAG_W-1:0]  grp_newtag,
   input  logic                    snap_save,
   input  logic [SW-1:0]           save_slot,
   input  logic                    snap_restore,
   input  logic [SW-1:0]           restore_slot,
   output logic [LANES*TAG_W-1:0]  tag_a,
   output logic [LANES*TAG_W-1:0]  tag_b,
   output logic [LANES*TAG_W-1:0]  dst_tag,
   output logic [LANES-1:0]        lane_nop,
   output logic [LANES-1:0]        lane_alloc
);

   typedef logic [NAREG-1:0][TAG_W-1:0] map_t;

   if ((2 ** TAG_W) < NAREG) begin : g_bad_tagw
      $error("TAG_W too narrow for NAREG");
   end
   if (IP_REG >= NAREG || ZERO_REG >= NAREG || IP_REG == ZERO_REG) begin : g_bad_rsvd
      $error("reserved register numbers invalid");
   end
   if (NCKPT < 2 || LANES < 1) begin : g_bad_count
      $error("need LANES >= 1 and NCKPT >= 2");
   end

   map_t                map_q;
   map_t                map_d;
   map_t                snap_rd;
   map_t [LANES:0]      chain;
   logic [LANES-1:0]    lane_go;

   assign chain[0] = map_q;
   assign lane_go  = snap_restore ? '0 : grp_valid;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      regmap_lane #(
         .NAREG(NAREG), .AW(AW), .TW(TAG_W),
         .IP_REG(IP_REG), .ZERO_REG(ZERO_REG),
         .IP_TAG(IP_TAG), .ZERO_TAG(ZERO_TAG)
      ) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .map_i   (chain[i]),
         .map_o   (chain[i+1]),
         .valid   (lane_go[i]),
         .is_move (grp_move[i]),
         .has_dst (grp_wr[i]),
         .dst     (grp_dst[i*AW +: AW]),
         .srca    (grp_srca[i*AW +: AW]),
         .srcb    (grp_srcb[i*AW +: AW]),
         .new_tag (grp_newtag[i*TAG_W +: TAG_W]),
         .tag_a   (tag_a[i*TAG_W +: TAG_W]),
         .tag_b   (tag_b[i*TAG_W +: TAG_W]),
         .dst_tag (dst_tag[i*TAG_W +: TAG_W]),
         .nop     (lane_nop[i]),
         .alloc   (lane_alloc[i])
      );
   end

   assign map_d = snap_restore ? snap_rd : chain[LANES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NAREG; r++) map_q[r] <= TAG_W'(r);
      end else begin
         map_q <= map_d;
      end
   end

   regmap_ckpt #(.NSLOT(NCKPT), .NAREG(NAREG), .TW(TAG_W), .SW(SW)) u_ckpt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (snap_save),
      .wr_slot (save_slot),
      .wr_map  (map_d),
      .rd_slot (restore_slot),
      .rd_map  (snap_rd)
   );

   // R9
   restore_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_restore |=> (map_q == $past(snap_rd)));

   // R9
   restore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_restore |-> (lane_nop == '0 && lane_alloc == '0));

   // R5
   zero_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(map_q[ZERO_REG]) && $stable(map_q[IP_REG]));

   // R1
   alloc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(lane_alloc) + $countones(lane_nop)) <= $countones(grp_valid));

endmodule

// File: tb/tb_regmap_movelim.sv
`timescale 1ns/1ps
module tb_regmap_movelim;

   localparam int L  = 4;
   localparam int NA = 64;
   localparam int AW = 6;
   localparam int TW = 8;
   localparam int NS = 4;
   localparam int SW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [L-1:0]     grp_valid, grp_move, grp_wr;
   logic [L*AW-1:0]  grp_dst, grp_srca, grp_srcb;
   logic [L*TW-1:0]  grp_newtag;
   logic             snap_save, snap_restore;
   logic [SW-1:0]    save_slot, restore_slot;
   logic [L*TW-1:0]  tag_a, tag_b, dst_tag;
   logic [L-1:0]     lane_nop, lane_alloc;

   regmap_movelim dut (.*);

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // staged stimulus
   int s_v[L], s_m[L], s_w[L], s_d[L], s_a[L], s_b[L], s_t[L];
   int s_save, s_sslot, s_rest, s_rslot;
   string force_lbl = "";

   // reference state
   int model[NA];
   int ck[NS][NA];

   task automatic chk(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   function automatic string lbl(input string dflt);
      return (force_lbl != "") ? force_lbl : dflt;
   endfunction

   function automatic int rdm(input int r, input int w[NA]);
      if (r == 62) return 62;
      if (r == 63) return 63;
      return w[r];
   endfunction

   task automatic clear_stage();
      for (int i = 0; i < L; i++) begin
         s_v[i] = 0; s_m[i] = 0; s_w[i] = 0; s_d[i] = 0; s_a[i] = 0; s_b[i] = 0; s_t[i] = 64;
      end
      s_save = 0; s_sslot = 0; s_rest = 0; s_rslot = 0;
   endtask

   task automatic cyc();
      int w[NA];
      bit touched[NA];
      @(negedge clk);
      for (int i = 0; i < L; i++) begin
         grp_valid[i] = s_v[i][0]; grp_move[i] = s_m[i][0]; grp_wr[i] = s_w[i][0];
         grp_dst[i*AW +: AW]  = AW'(s_d[i]);
         grp_srca[i*AW +: AW] = AW'(s_a[i]);
         grp_srcb[i*AW +: AW] = AW'(s_b[i]);
         grp_newtag[i*TW +: TW] = TW'(s_t[i]);
      end
      snap_save = s_save[0]; save_slot = SW'(s_sslot);
      snap_restore = s_rest[0]; restore_slot = SW'(s_rslot);
      #1;
      w = model;
      for (int r = 0; r < NA; r++) touched[r] = 0;
      if (s_rest != 0) begin
         for (int i = 0; i < L; i++) begin
            chk(int'(lane_nop[i]), 0, "R9", "nop during restore");
            chk(int'(lane_alloc[i]), 0, "R9", "alloc during restore");
         end
         w = ck[s_rslot];
      end else begin
         for (int i = 0; i < L; i++) begin
            if (s_v[i] == 0) begin
               chk(int'(lane_nop[i]), 0, "R11", "idle nop");
               chk(int'(lane_alloc[i]), 0, "R11", "idle alloc");
            end else begin
               int ea, eb, wt;
               bit elim, rsv, wr;
               string la, lb;
               ea = rdm(s_a[i], w);
               eb = rdm(s_b[i], w);
               la = (s_a[i] == 62) ? "R4" : (s_a[i] == 63) ? "R5" :
                    (s_a[i] == 0) ? "R6" : touched[s_a[i]] ? "R7" : "R2";
               lb = (s_b[i] == 62) ? "R4" : (s_b[i] == 63) ? "R5" :
                    (s_b[i] == 0) ? "R6" : touched[s_b[i]] ? "R7" : "R2";
               chk(int'(tag_a[i*TW +: TW]), ea, lbl(la), "tag_a");
               chk(int'(tag_b[i*TW +: TW]), eb, lbl(lb), "tag_b");
               elim = (s_m[i] != 0) && (s_a[i] != 62);
               rsv  = (s_d[i] >= 62);
               wr   = !rsv && (elim || (s_w[i] != 0));
               chk(int'(lane_nop[i]), int'(elim), lbl(elim ? "R3" : "R4"), "nop");
               chk(int'(lane_alloc[i]), int'(wr && !elim),
                   lbl(rsv ? "R5" : elim ? "R3" : "R1"), "alloc");
               if (wr) begin
                  wt = elim ? ea : s_t[i];
                  chk(int'(dst_tag[i*TW +: TW]), wt, lbl(elim ? "R3" : "R1"), "dst_tag");
                  w[s_d[i]] = wt;
                  touched[s_d[i]] = 1;
               end
            end
         end
      end
      if (s_save != 0) ck[s_sslot] = w;
      model = w;
      @(posedge clk);
   endtask

   // read registers base..base+7 through all lanes without writing
   task automatic probe(input int base, input string req);
      clear_stage();
      for (int i = 0; i < L; i++) begin
         s_v[i] = 1; s_a[i] = base + 2*i; s_b[i] = base + 2*i + 1;
      end
      force_lbl = req;
      cyc();
      force_lbl = "";
   endtask

   function automatic int pick_reg();
      int u;
      u = $urandom_range(0, 99);
      if (u < 80) return u % 8;
      if (u < 90) return 62 + (u % 2);
      return $urandom_range(0, 63);
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(7));
      for (int r = 0; r < NA; r++) begin
         model[r] = r;
         for (int s = 0; s < NS; s++) ck[s][r] = r;
      end
      clear_stage();
      grp_valid = '0; grp_move = '0; grp_wr = '0; grp_dst = '0; grp_srca = '0;
      grp_srcb = '0; grp_newtag = '0; snap_save = 0; snap_restore = 0;
      save_slot = '0; restore_slot = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset map, 8 registers per probe
      for (int b = 0; b < NA; b += 8) probe(b, "R10");

      // R1 / R6 write r0 then read it
      clear_stage();
      s_v[0] = 1; s_w[0] = 1; s_d[0] = 0; s_t[0] = 200;
      cyc();
      probe(0, "R6");

      // R7 move chain inside one group: r1<-new, r2<-r1 (move), r3<-r2 (move), read r3
      clear_stage();
      s_v[0] = 1; s_w[0] = 1; s_d[0] = 1; s_t[0] = 150;
      s_v[1] = 1; s_m[1] = 1; s_w[1] = 1; s_d[1] = 2; s_a[1] = 1;
      s_v[2] = 1; s_m[2] = 1; s_w[2] = 1; s_d[2] = 3; s_a[2] = 2;
      s_v[3] = 1; s_a[3] = 3; s_b[3] = 2;
      force_lbl = "R7"; cyc(); force_lbl = "";

      // R4 move from IP is not eliminated; write to IP discarded
      clear_stage();
      s_v[0] = 1; s_m[0] = 1; s_w[0] = 1; s_d[0] = 4; s_a[0] = 62; s_t[0] = 99;
      s_v[1] = 1; s_w[1] = 1; s_d[1] = 62; s_t[1] = 98;
      s_v[2] = 1; s_a[2] = 4; s_b[2] = 62;
      cyc();

      // R5 move and write into zero register discarded
      clear_stage();
      s_v[0] = 1; s_m[0] = 1; s_w[0] = 1; s_d[0] = 63; s_a[0] = 1;
      s_v[1] = 1; s_w[1] = 1; s_d[1] = 63; s_t[1] = 97;
      s_v[2] = 1; s_a[2] = 63; s_b[2] = 63;
      s_v[3] = 1; s_m[3] = 1; s_w[3] = 1; s_d[3] = 5; s_a[3] = 63;
      cyc();

      // R8 save post-update map, then alter, then R9 restore with a busy group
      clear_stage();
      s_v[0] = 1; s_w[0] = 1; s_d[0] = 6; s_t[0] = 180;
      s_save = 1; s_sslot = 2;
      cyc();
      clear_stage();
      s_v[0] = 1; s_w[0] = 1; s_d[0] = 6; s_t[0] = 181;
      cyc();
      clear_stage();
      for (int i = 0; i < L; i++) begin
         s_v[i] = 1; s_w[i] = 1; s_d[i] = i + 6; s_t[i] = 240 + i;
      end
      s_rest = 1; s_rslot = 2;
      cyc();
      probe(0, "R8");

      // randomized run compared against the model every cycle
      for (int n = 0; n < 3000; n++) begin
         clear_stage();
         for (int i = 0; i < L; i++) begin
            s_v[i] = ($urandom_range(0, 99) < 85) ? 1 : 0;
            s_m[i] = ($urandom_range(0, 99) < 30) ? 1 : 0;
            s_w[i] = (s_m[i] != 0 || $urandom_range(0, 99) < 80) ? 1 : 0;
            s_d[i] = pick_reg();
            s_a[i] = pick_reg();
            s_b[i] = pick_reg();
            s_t[i] = $urandom_range(64, 255);
         end
         s_save  = ($urandom_range(0, 99) < 10) ? 1 : 0;
         s_sslot = $urandom_range(0, NS-1);
         s_rest  = ($urandom_range(0, 99) < 5) ? 1 : 0;
         s_rslot = $urandom_range(0, NS-1);
         cyc();
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule